// File: doc/BRIEF.md
# DMA Address Counter with Next-Address Autoload

This block keeps the running memory address and a 24-bit remaining-byte count for a DMA channel. Each accepted byte transfer moves the address up by one and the count down by one. When the count reaches zero the block raises a one-cycle count-zero event. It also produces a DMA-active status that gates the requests arriving from the attached device.

To allow back-to-back transfers without a gap, the block has a second pair of registers that software cannot see directly: a next address and a next count. While autoload is enabled, software writes to the address and count locations land in these shadow registers. The current values keep running untouched. When the current count runs out, the block acts on whether a next address has been supplied since the last expiry. If one has, the shadow pair is copied into the current pair on the same clock edge. If not, the channel stalls and ignores device requests. A later next-address write restarts it, and the copy is made before any further byte is counted.

Top module: `dma_autoload_addr`

## Requirements
- R1: The current count is 24 bits wide. A write to the count location keeps only bits 23:0 of the write data, and bits above 23 have no effect.
- R2: With autoload enabled, an address write goes to the next-address register and sets the next-loaded flag. A count write goes to the next-count register. Neither write changes the current address or the current count.
- R3: With autoload enabled and next-loaded set, the transfer that takes the count from 1 to 0 loads the next address and next count into the current registers on that same edge. It also clears next-loaded, keeps address-loaded set, and raises the count-zero event.
- R4: A count expiry without a pending next address clears address-loaded and leaves the count at 0. DMA-active and the request grant then stay 0, and further transfer strobes change neither the address nor the count.
- R5: During a stall with autoload enabled, a next-address write sets next-loaded on its edge. The following edge copies the next pair into the current pair, sets address-loaded and clears next-loaded. No transfer strobe is counted on either edge.
- R6: Each accepted transfer adds 1 to the current address and subtracts 1 from the current count. A transfer is accepted only while DMA-active and address-loaded are both 1. The count-zero event is 1 for exactly the cycle after the edge on which the count reached zero.
- R7: DMA-active is 1 exactly when (address-loaded or next-loaded) is 1, DMA enable is 1, and the error-pending input is 0. The request grant equals the device request ANDed with DMA-active.
- R8: With autoload disabled, writes go straight to the current address and current count, and an address write sets address-loaded. Clearing autoload also clears next-loaded.
- R9: After reset the address, the count, both loaded flags, the count-zero event, DMA-active and the grant are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_addr_i | input | 1 | Write strobe for the address location |
| wr_cnt_i | input | 1 | Write strobe for the count location |
| wr_data_i | input | ADDR_W | Write data for either location |
| autoload_i | input | 1 | Steers writes to the shadow registers and enables reload |
| dma_en_i | input | 1 | DMA enable |
| err_pend_i | input | 1 | Memory error pending, which stops DMA |
| xfer_i | input | 1 | One byte transferred in this cycle |
| dev_req_i | input | 1 | Device DMA request |
| cur_addr_o | output | ADDR_W | Current DMA address |
| cur_cnt_o | output | CNT_W | Current remaining byte count |
| tc_o | output | 1 | Count-zero event, one cycle |
| dma_active_o | output | 1 | DMA-active status |
| dev_grant_o | output | 1 | Device request passed through the DMA-active gate |
| addr_loaded_o | output | 1 | Current address valid |
| next_loaded_o | output | 1 | Next address written since the last expiry |

## Verification
The assertions assume that the write strobes, the autoload setting and the transfer strobe are held stable across each clock edge. They also assume that a transfer strobe is only meaningful as one byte per cycle. Several properties leave out cycles in which an address write coincides with a count expiry, because the outcome there depends on which of the two is considered first. The directed stimulus changes inputs only on the falling edge. It never makes a write in the same cycle as the expiring transfer, so every expected value has a single reading.

// File: rtl/dma_al_pkg.sv
package dma_al_pkg;

  // Decisions made each cycle by the control logic.
  typedef struct packed {
    logic active;       // DMA-active status
    logic accept;       // a byte transfer is counted this cycle
    logic expire;       // counted transfer takes count to zero
    logic reload;       // copy shadow pair into current pair
    logic aload_clr;    // current address runs out with no reload
    logic cur_wr_addr;  // direct write to current address
    logic cur_wr_cnt;   // direct write to current count
    logic nxt_wr_addr;  // write steered to next address
    logic nxt_wr_cnt;   // write steered to next count
  } al_ctl_t;

endpackage

// File: rtl/dma_al_ctrl.sv
module dma_al_ctrl
  import dma_al_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             autoload_i,
  input  logic             dma_en_i,
  input  logic             err_i,
  input  logic             xfer_i,
  input  logic             wr_addr_i,
  input  logic             wr_cnt_i,
  input  logic             aload_i,
  input  logic             naload_i,
  input  logic [CNT_W-1:0] cnt_i,
  output al_ctl_t          ctl_o
);

  logic last_byte;
  logic stall_restart;

  assign last_byte     = (cnt_i == CNT_W'(1));
  assign stall_restart = autoload_i & naload_i & ~aload_i;

  always_comb begin
    ctl_o             = '0;
    ctl_o.active      = (aload_i | naload_i) & dma_en_i & ~err_i;
    ctl_o.accept      = xfer_i & ctl_o.active & aload_i;
    ctl_o.expire      = ctl_o.accept & last_byte;
    ctl_o.reload      = (ctl_o.expire & autoload_i & naload_i) | stall_restart;
    ctl_o.aload_clr   = ctl_o.expire & ~(autoload_i & naload_i);
    ctl_o.cur_wr_addr = wr_addr_i & ~autoload_i;
    ctl_o.cur_wr_cnt  = wr_cnt_i  & ~autoload_i;
    ctl_o.nxt_wr_addr = wr_addr_i &  autoload_i;
    ctl_o.nxt_wr_cnt  = wr_cnt_i  &  autoload_i;
  end

endmodule

// File: rtl/dma_al_shadow.sv
module dma_al_shadow
  import dma_al_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              autoload_i,
  input  al_ctl_t           ctl_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] nxt_addr_o,
  output logic [CNT_W-1:0]  nxt_cnt_o,
  output logic              naload_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              naload_q, naload_d;
  logic              naload_en;

  // Next-loaded flag: set by a steered write, dropped when consumed
  // by a reload or when autoload is switched off.
  always_comb begin
    naload_d = naload_q;
    if (!autoload_i)             naload_d = 1'b0;
    else if (ctl_i.nxt_wr_addr)  naload_d = 1'b1;
    else if (ctl_i.reload)       naload_d = 1'b0;
  end
  assign naload_en = (naload_d != naload_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      cnt_q    <= '0;
      naload_q <= 1'b0;
    end else begin
      if (ctl_i.nxt_wr_addr) addr_q   <= wr_data_i;
      if (ctl_i.nxt_wr_cnt)  cnt_q    <= wr_data_i[CNT_W-1:0];
      if (naload_en)         naload_q <= naload_d;
    end
  end

  assign nxt_addr_o = addr_q;
  assign nxt_cnt_o  = cnt_q;
  assign naload_o   = naload_q;

endmodule

// File: rtl/dma_al_cur.sv
module dma_al_cur
  import dma_al_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  al_ctl_t           ctl_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] nxt_addr_i,
  input  logic [CNT_W-1:0]  nxt_cnt_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              aload_o,
  output logic              tc_o
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              aload_q, aload_d;
  logic              tc_q;
  logic              upd_en;

  always_comb begin
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    aload_d = aload_q;
    if (ctl_i.reload) begin
      addr_d  = nxt_addr_i;
      cnt_d   = nxt_cnt_i;
      aload_d = 1'b1;
    end else begin
      if (ctl_i.accept) begin
        addr_d = addr_q + ADDR_W'(1);
        cnt_d  = cnt_q - CNT_W'(1);
        if (ctl_i.aload_clr) aload_d = 1'b0;
      end
      if (ctl_i.cur_wr_addr) begin
        addr_d  = wr_data_i;
        aload_d = 1'b1;
      end
      if (ctl_i.cur_wr_cnt) cnt_d = wr_data_i[CNT_W-1:0];
    end
  end

  assign upd_en = ctl_i.reload | ctl_i.accept | ctl_i.cur_wr_addr | ctl_i.cur_wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      aload_q <= 1'b0;
      tc_q    <= 1'b0;
    end else begin
      tc_q <= ctl_i.expire;
      if (upd_en) begin
        addr_q  <= addr_d;
        cnt_q   <= cnt_d;
        aload_q <= aload_d;
      end
    end
  end

  assign addr_o  = addr_q;
  assign cnt_o   = cnt_q;
  assign aload_o = aload_q;
  assign tc_o    = tc_q;

endmodule

// File: rtl/dma_autoload_addr.sv
module dma_autoload_addr
  import dma_al_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n_i,
  input  logic              wr_addr_i,
  input  logic              wr_cnt_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              autoload_i,
  input  logic              dma_en_i,
  input  logic              err_pend_i,
  input  logic              xfer_i,
  input  logic              dev_req_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [CNT_W-1:0]  cur_cnt_o,
  output logic              tc_o,
  output logic              dma_active_o,
  output logic              dev_grant_o,
  output logic              addr_loaded_o,
  output logic              next_loaded_o
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n;
  al_ctl_t                ctl;
  logic [ADDR_W-1:0]      nxt_addr;
  logic [CNT_W-1:0]       nxt_cnt;
  logic                   aload;
  logic                   naload;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= '0;
    else          rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n = rst_sync_q[SYNC_STAGES-1];

  dma_al_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .autoload_i (autoload_i),
    .dma_en_i   (dma_en_i),
    .err_i      (err_pend_i),
    .xfer_i     (xfer_i),
    .wr_addr_i  (wr_addr_i),
    .wr_cnt_i   (wr_cnt_i),
    .aload_i    (aload),
    .naload_i   (naload),
    .cnt_i      (cur_cnt_o),
    .ctl_o      (ctl)
  );

  dma_al_shadow #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .autoload_i (autoload_i),
    .ctl_i      (ctl),
    .wr_data_i  (wr_data_i),
    .nxt_addr_o (nxt_addr),
    .nxt_cnt_o  (nxt_cnt),
    .naload_o   (naload)
  );

  dma_al_cur #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cur (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_i      (ctl),
    .wr_data_i  (wr_data_i),
    .nxt_addr_i (nxt_addr),
    .nxt_cnt_i  (nxt_cnt),
    .addr_o     (cur_addr_o),
    .cnt_o      (cur_cnt_o),
    .aload_o    (aload),
    .tc_o       (tc_o)
  );

  assign dma_active_o  = ctl.active;
  assign dev_grant_o   = dev_req_i & ctl.active;
  assign addr_loaded_o = aload;
  assign next_loaded_o = naload;

endmodule

// File: rtl/dma_autoload_addr_chk.sv
module dma_autoload_addr_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_addr_i,
  input logic              autoload_i,
  input logic              dma_en_i,
  input logic              err_pend_i,
  input logic              xfer_i,
  input logic              wr_cnt_i,
  input logic              accept,
  input logic              expire,
  input logic [ADDR_W-1:0] nxt_addr,
  input logic [ADDR_W-1:0] cur_addr_o,
  input logic [CNT_W-1:0]  cur_cnt_o,
  input logic              tc_o,
  input logic              dma_active_o,
  input logic              dev_grant_o,
  input logic              addr_loaded_o,
  input logic              next_loaded_o
);

  // R2: a steered address write leaves the current address alone
  a_r2_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (autoload_i && wr_addr_i && addr_loaded_o && !xfer_i)
    |=> ($stable(cur_addr_o) && next_loaded_o));

  // R3: reload on expiry with a pending next address
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && autoload_i && next_loaded_o && !wr_addr_i)
    |=> (addr_loaded_o && !next_loaded_o && tc_o && cur_addr_o == $past(nxt_addr)));

  // R4: expiry without a pending next address stalls
  a_r4_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !(autoload_i && next_loaded_o) && !wr_addr_i)
    |=> (!addr_loaded_o && !dma_active_o && tc_o && cur_cnt_o == '0));

  // R5: restart copies the next pair before counting resumes
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (autoload_i && next_loaded_o && !addr_loaded_o && !wr_addr_i)
    |=> (addr_loaded_o && !next_loaded_o && cur_addr_o == $past(nxt_addr)));

  // R6: one accepted byte moves address and count by one
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !expire && !wr_addr_i && !wr_cnt_i)
    |=> (cur_addr_o == $past(cur_addr_o) + ADDR_W'(1)
         && cur_cnt_o == $past(cur_cnt_o) - CNT_W'(1)));

  // R6: count-zero event follows a count of one
  a_r6_tc_source: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> ($past(cur_cnt_o) == CNT_W'(1)));

  // R7: disable or a pending error blocks requests
  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en_i || err_pend_i) |-> (!dma_active_o && !dev_grant_o));

  // R7: nothing loaded means not active
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_loaded_o && !next_loaded_o) |-> !dma_active_o);

endmodule

bind dma_autoload_addr dma_autoload_addr_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_addr_i     (wr_addr_i),
  .autoload_i    (autoload_i),
  .dma_en_i      (dma_en_i),
  .err_pend_i    (err_pend_i),
  .xfer_i        (xfer_i),
  .wr_cnt_i      (wr_cnt_i),
  .accept        (ctl.accept),
  .expire        (ctl.expire),
  .nxt_addr      (nxt_addr),
  .cur_addr_o    (cur_addr_o),
  .cur_cnt_o     (cur_cnt_o),
  .tc_o          (tc_o),
  .dma_active_o  (dma_active_o),
  .dev_grant_o   (dev_grant_o),
  .addr_loaded_o (addr_loaded_o),
  .next_loaded_o (next_loaded_o)
);

// File: tb/dma_autoload_addr_tb.sv
`timescale 1ns/1ps
module dma_autoload_addr_tb;

  localparam int ADDR_W = 32;
  localparam int CNT_W  = 24;

  logic              clk = 1'b0;
  logic              rst_n_i;
  logic              wr_addr_i, wr_cnt_i;
  logic [ADDR_W-1:0] wr_data_i;
  logic              autoload_i, dma_en_i, err_pend_i, xfer_i, dev_req_i;
  logic [ADDR_W-1:0] cur_addr_o;
  logic [CNT_W-1:0]  cur_cnt_o;
  logic              tc_o, dma_active_o, dev_grant_o, addr_loaded_o, next_loaded_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dma_autoload_addr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n_i(rst_n_i), .wr_addr_i(wr_addr_i), .wr_cnt_i(wr_cnt_i),
    .wr_data_i(wr_data_i), .autoload_i(autoload_i), .dma_en_i(dma_en_i),
    .err_pend_i(err_pend_i), .xfer_i(xfer_i), .dev_req_i(dev_req_i),
    .cur_addr_o(cur_addr_o), .cur_cnt_o(cur_cnt_o), .tc_o(tc_o),
    .dma_active_o(dma_active_o), .dev_grant_o(dev_grant_o),
    .addr_loaded_o(addr_loaded_o), .next_loaded_o(next_loaded_o)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(bit is_addr, logic [ADDR_W-1:0] data);
    wr_data_i = data;
    if (is_addr) wr_addr_i = 1'b1; else wr_cnt_i = 1'b1;
    tick();
    wr_addr_i = 1'b0;
    wr_cnt_i  = 1'b0;
  endtask

  task automatic xfer(int n);
    for (int i = 0; i < n; i++) begin
      xfer_i = 1'b1;
      tick();
    end
    xfer_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9", "addr", cur_addr_o, 0);
    chk("R9", "cnt", cur_cnt_o, 0);
    chk("R9", "flags", {tc_o, dma_active_o, dev_grant_o, addr_loaded_o, next_loaded_o}, 0);
  endtask

  task automatic t_direct();
    autoload_i = 1'b0;
    wr(1'b0, 32'hAB12_3456);
    chk("R1", "count keeps 24 bits", cur_cnt_o, 32'h0012_3456);
    wr(1'b0, 32'd3);
    wr(1'b1, 32'h1000);
    chk("R8", "direct addr", cur_addr_o, 32'h1000);
    chk("R8", "addr loaded", addr_loaded_o, 1);
    chk("R7", "active", dma_active_o, 1);
    chk("R7", "grant", dev_grant_o, 1);
    xfer(2);
    chk("R6", "addr +2", cur_addr_o, 32'h1002);
    chk("R6", "cnt -2", cur_cnt_o, 1);
    chk("R6", "no tc yet", tc_o, 0);
    xfer(1);
    chk("R6", "tc on zero", tc_o, 1);
    chk("R4", "cnt zero", cur_cnt_o, 0);
    chk("R4", "aload cleared", addr_loaded_o, 0);
    chk("R4", "inactive", dma_active_o, 0);
    tick();
    chk("R6", "tc one cycle", tc_o, 0);
  endtask

  task automatic t_reload();
    wr(1'b0, 32'd2);
    wr(1'b1, 32'h4000);
    autoload_i = 1'b1;
    tick();
    wr(1'b0, 32'd5);
    chk("R2", "cur cnt kept", cur_cnt_o, 2);
    wr(1'b1, 32'h2000);
    chk("R2", "cur addr kept", cur_addr_o, 32'h4000);
    chk("R2", "next loaded", next_loaded_o, 1);
    xfer(1);
    chk("R6", "addr step", cur_addr_o, 32'h4001);
    xfer(1);
    chk("R3", "addr reloaded", cur_addr_o, 32'h2000);
    chk("R3", "cnt reloaded", cur_cnt_o, 5);
    chk("R3", "next consumed", next_loaded_o, 0);
    chk("R3", "still loaded", addr_loaded_o, 1);
    chk("R3", "tc", tc_o, 1);
  endtask

  task automatic t_stall();
    xfer(5);
    chk("R4", "addr end", cur_addr_o, 32'h2005);
    chk("R4", "aload off", addr_loaded_o, 0);
    chk("R4", "inactive", dma_active_o, 0);
    xfer(3);
    chk("R4", "addr frozen", cur_addr_o, 32'h2005);
    chk("R4", "cnt frozen", cur_cnt_o, 0);
    chk("R4", "grant blocked", dev_grant_o, 0);
  endtask

  task automatic t_restart();
    wr(1'b0, 32'd2);
    wr_data_i = 32'h3000;
    wr_addr_i = 1'b1;
    xfer_i    = 1'b1;
    tick();
    wr_addr_i = 1'b0;
    chk("R5", "next loaded", next_loaded_o, 1);
    chk("R5", "not yet loaded", addr_loaded_o, 0);
    chk("R5", "active", dma_active_o, 1);
    chk("R5", "addr unchanged", cur_addr_o, 32'h2005);
    tick();
    xfer_i = 1'b0;
    chk("R5", "addr copied", cur_addr_o, 32'h3000);
    chk("R5", "cnt copied", cur_cnt_o, 2);
    chk("R5", "aload set", addr_loaded_o, 1);
    chk("R5", "next cleared", next_loaded_o, 0);
    xfer(2);
    chk("R4", "stall again", addr_loaded_o, 0);
    chk("R6", "addr after two", cur_addr_o, 32'h3002);
  endtask

  task automatic t_autoload_off();
    autoload_i = 1'b0;
    tick();
    wr(1'b1, 32'h5000);
    wr(1'b0, 32'd4);
    chk("R8", "direct after clear", cur_addr_o, 32'h5000);
    autoload_i = 1'b1;
    tick();
    wr(1'b1, 32'h6000);
    chk("R2", "next pending", next_loaded_o, 1);
    autoload_i = 1'b0;
    tick();
    chk("R8", "next dropped", next_loaded_o, 0);
    chk("R8", "cur kept", cur_addr_o, 32'h5000);
  endtask

  task automatic t_gate();
    err_pend_i = 1'b1;
    tick();
    chk("R7", "err inactive", dma_active_o, 0);
    chk("R7", "err no grant", dev_grant_o, 0);
    xfer(1);
    chk("R7", "err no step", cur_addr_o, 32'h5000);
    err_pend_i = 1'b0;
    tick();
    chk("R7", "active again", dma_active_o, 1);
    dma_en_i = 1'b0;
    tick();
    chk("R7", "disabled", dma_active_o, 0);
    chk("R7", "disabled grant", dev_grant_o, 0);
    dma_en_i = 1'b1;
  endtask

  initial begin
    rst_n_i = 1'b0; wr_addr_i = 1'b0; wr_cnt_i = 1'b0; wr_data_i = '0;
    autoload_i = 1'b0; dma_en_i = 1'b0; err_pend_i = 1'b0; xfer_i = 1'b0;
    dev_req_i = 1'b0;
    repeat (3) tick();
    rst_n_i = 1'b1;
    repeat (3) tick();
    t_reset();
    dma_en_i  = 1'b1;
    dev_req_i = 1'b1;
    t_direct();
    t_reload();
    t_stall();
    t_restart();
    t_autoload_off();
    t_gate();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule